// File: doc/BRIEF.md
# Saturating Up/Down Counter Field

A single counter field of a register, updated by hardware through increment and decrement strobes. Each step is either a fixed value of one or a per-cycle amount taken from a step input, depending on a width parameter. A load input can replace the stored value, and any count requested in that cycle is applied to the loaded value rather than to the old one.

Each direction is built either to saturate or to wrap. A saturating direction stops at a configurable limit: a ceiling for counting up and a floor for counting down. A wrapping direction rolls over modulo 2^WIDTH and raises a single-cycle overflow or underflow flag. When both strobes are active in one cycle, the increment is applied first and the decrement acts on its result. Four status outputs compare the stored value against an upper and a lower threshold and against the two saturation limits.

Top module: `ctr_field`

## Requirements
- R1: Reset loads RESET_VAL asynchronously. With load_i, inc_i and dec_i all low, the count holds its value.
- R2: inc_i adds the step. The step is inc_step_i when STEP_W > 0. It is a fixed 1 when STEP_W = 0, and the step inputs are then ignored.
- R3: dec_i subtracts the step. The step is dec_step_i when STEP_W > 0, or 1 otherwise.
- R4: With inc_i and dec_i both high, the increment, including its saturation, is applied first. The decrement, including its saturation, then acts on that result.
- R5: With load_i high, the count is applied to load_val_i in the same cycle instead of to the stored value.
- R6: With UP_SAT = 1, an increment whose widened sum exceeds UP_LIMIT gives UP_LIMIT.
- R7: With DN_SAT = 1, a decrement from value v with step s gives DN_LIMIT when v < s + DN_LIMIT.
- R8: In a saturating direction, a next value beyond the limit, including a loaded one, is forced back to UP_LIMIT or DN_LIMIT.
- R9: With UP_SAT = 0, overflow_o is high in the same cycle as an increment whose widened sum exceeds 2^WIDTH-1, and the value wraps. overflow_o is 0 without an increment and is always 0 with UP_SAT = 1.
- R10: With DN_SAT = 0, underflow_o is high in the same cycle as a decrement whose step exceeds the value being decremented, and the value wraps. underflow_o is 0 otherwise and is always 0 with DN_SAT = 1.
- R11: up_thr_o is (stored value >= UP_THRESH), and dn_thr_o is (stored value <= DN_THRESH).
- R12: up_sat_o is (stored value >= UP_LIMIT), and dn_sat_o is (stored value <= DN_LIMIT).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Replace the stored value with load_val_i |
| load_val_i | input | WIDTH | Value to load |
| inc_i | input | 1 | Increment strobe |
| dec_i | input | 1 | Decrement strobe |
| inc_step_i | input | max(STEP_W,1) | Increment amount (used when STEP_W > 0) |
| dec_step_i | input | max(STEP_W,1) | Decrement amount (used when STEP_W > 0) |
| cnt_o | output | WIDTH | Stored count |
| up_thr_o | output | 1 | Stored value at or above the upper threshold |
| dn_thr_o | output | 1 | Stored value at or below the lower threshold |
| up_sat_o | output | 1 | Stored value at or above the ceiling |
| dn_sat_o | output | 1 | Stored value at or below the floor |
| overflow_o | output | 1 | Wrap on increment in this cycle |
| underflow_o | output | 1 | Wrap on decrement in this cycle |

## Verification
A saturating instance with variable steps runs a vector table of single increments, single decrements, mixed strobes and loads combined with counts. The mixed cases near the ceiling and the floor are chosen so that applying the decrement first would give a different value, which pins down the ordering. Loads above the ceiling and below the floor separate the final clamp from the counting path. A second, wrapping instance with a fixed step drives the value across zero in both directions, which separates a genuine wrap pulse from a flag that merely follows a strobe.

// File: rtl/ctr_pkg.sv
package ctr_pkg;
  typedef struct packed {
    logic up_thr;
    logic dn_thr;
    logic up_sat;
    logic dn_sat;
  } ctr_flags_t;
endpackage

// File: rtl/ctr_up_stage.sv
module ctr_up_stage #(
  parameter int unsigned WIDTH = 8,
  parameter bit          SAT   = 1'b1,
  parameter int unsigned LIMIT = (1 << WIDTH) - 1
) (
  input  logic [WIDTH-1:0] base_i,
  input  logic             en_i,
  input  logic [WIDTH:0]   step_i,
  output logic [WIDTH-1:0] res_o,
  output logic             ovf_o
);
  localparam logic [WIDTH:0] LIM_X = (WIDTH+1)'(LIMIT);
  logic [WIDTH:0] sum;
  assign sum = {1'b0, base_i} + step_i;

  if (SAT) begin : g_sat
    assign res_o = !en_i ? base_i : (sum > LIM_X) ? LIM_X[WIDTH-1:0] : sum[WIDTH-1:0];
    assign ovf_o = 1'b0;
  end else begin : g_wrap
    assign res_o = en_i ? sum[WIDTH-1:0] : base_i;
    assign ovf_o = en_i & sum[WIDTH];
  end
endmodule

// File: rtl/ctr_dn_stage.sv
module ctr_dn_stage #(
  parameter int unsigned WIDTH = 8,
  parameter bit          SAT   = 1'b1,
  parameter int unsigned FLOOR = 0
) (
  input  logic [WIDTH-1:0] base_i,
  input  logic             en_i,
  input  logic [WIDTH:0]   step_i,
  output logic [WIDTH-1:0] res_o,
  output logic             unf_o
);
  localparam logic [WIDTH:0] FLR_X = (WIDTH+1)'(FLOOR);
  logic [WIDTH-1:0] diff;
  logic [WIDTH:0]   base_x;
  assign base_x = {1'b0, base_i};
  assign diff   = base_i - step_i[WIDTH-1:0];

  if (SAT) begin : g_sat
    logic [WIDTH:0] low;
    assign low   = step_i + FLR_X;
    assign res_o = !en_i ? base_i : (base_x < low) ? FLR_X[WIDTH-1:0] : diff;
    assign unf_o = 1'b0;
  end else begin : g_wrap
    assign res_o = en_i ? diff : base_i;
    assign unf_o = en_i & (base_x < step_i);
  end
endmodule

// File: rtl/ctr_flag_gen.sv
module ctr_flag_gen
  import ctr_pkg::*;
#(
  parameter int unsigned WIDTH     = 8,
  parameter int unsigned UP_THRESH = (1 << WIDTH) - 1,
  parameter int unsigned DN_THRESH = 0,
  parameter int unsigned UP_LIMIT  = (1 << WIDTH) - 1,
  parameter int unsigned DN_LIMIT  = 0
) (
  input  logic [WIDTH-1:0] cnt_i,
  output ctr_flags_t       flags_o
);
  localparam logic [WIDTH-1:0] UT = WIDTH'(UP_THRESH);
  localparam logic [WIDTH-1:0] DT = WIDTH'(DN_THRESH);
  localparam logic [WIDTH-1:0] UL = WIDTH'(UP_LIMIT);
  localparam logic [WIDTH-1:0] DL = WIDTH'(DN_LIMIT);

  assign flags_o.up_thr = cnt_i >= UT;
  assign flags_o.dn_thr = cnt_i <= DT;
  assign flags_o.up_sat = cnt_i >= UL;
  assign flags_o.dn_sat = cnt_i <= DL;
endmodule

// File: rtl/ctr_field.sv
module ctr_field
  import ctr_pkg::*;
#(
  parameter int unsigned WIDTH     = 8,
  parameter int unsigned STEP_W    = 4,
  parameter bit          UP_SAT    = 1'b1,
  parameter bit          DN_SAT    = 1'b1,
  parameter int unsigned UP_LIMIT  = (1 << WIDTH) - 1,
  parameter int unsigned DN_LIMIT  = 0,
  parameter int unsigned UP_THRESH = (1 << WIDTH) - 1,
  parameter int unsigned DN_THRESH = 0,
  parameter int unsigned RESET_VAL = 0,
  localparam int unsigned STEP_PW  = (STEP_W > 0) ? STEP_W : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [WIDTH-1:0]   load_val_i,
  input  logic               inc_i,
  input  logic               dec_i,
  input  logic [STEP_PW-1:0] inc_step_i,
  input  logic [STEP_PW-1:0] dec_step_i,
  output logic [WIDTH-1:0]   cnt_o,
  output logic               up_thr_o,
  output logic               dn_thr_o,
  output logic               up_sat_o,
  output logic               dn_sat_o,
  output logic               overflow_o,
  output logic               underflow_o
);
  localparam logic [WIDTH-1:0] UL = WIDTH'(UP_LIMIT);
  localparam logic [WIDTH-1:0] DL = WIDTH'(DN_LIMIT);

  logic [WIDTH-1:0] cnt_q, base, mid, post, nxt;
  logic [WIDTH:0]   inc_amt, dec_amt;
  ctr_flags_t       flags;

  if (STEP_W == 0) begin : g_fixed_step
    logic steps_unused;
    assign steps_unused = ^{inc_step_i, dec_step_i};
    assign inc_amt = (WIDTH+1)'(1);
    assign dec_amt = (WIDTH+1)'(1);
  end else begin : g_var_step
    assign inc_amt = (WIDTH+1)'(inc_step_i);
    assign dec_amt = (WIDTH+1)'(dec_step_i);
  end

  assign base = load_i ? load_val_i : cnt_q;

  // increment first, then decrement on its result
  ctr_up_stage #(.WIDTH(WIDTH), .SAT(UP_SAT), .LIMIT(UP_LIMIT)) u_up (
    .base_i(base), .en_i(inc_i), .step_i(inc_amt), .res_o(mid), .ovf_o(overflow_o)
  );

  ctr_dn_stage #(.WIDTH(WIDTH), .SAT(DN_SAT), .FLOOR(DN_LIMIT)) u_dn (
    .base_i(mid), .en_i(dec_i), .step_i(dec_amt), .res_o(post), .unf_o(underflow_o)
  );

  // clamp loads that land outside a saturating range
  always_comb begin
    nxt = post;
    if (UP_SAT && (nxt > UL)) nxt = UL;
    if (DN_SAT && (nxt < DL)) nxt = DL;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= WIDTH'(RESET_VAL);
    else         cnt_q <= nxt;
  end

  ctr_flag_gen #(
    .WIDTH(WIDTH), .UP_THRESH(UP_THRESH), .DN_THRESH(DN_THRESH),
    .UP_LIMIT(UP_LIMIT), .DN_LIMIT(DN_LIMIT)
  ) u_flags (
    .cnt_i(cnt_q), .flags_o(flags)
  );

  assign cnt_o    = cnt_q;
  assign up_thr_o = flags.up_thr;
  assign dn_thr_o = flags.dn_thr;
  assign up_sat_o = flags.up_sat;
  assign dn_sat_o = flags.dn_sat;
endmodule

// File: rtl/ctr_field_chk.sv
module ctr_field_chk #(
  parameter int unsigned WIDTH    = 8,
  parameter bit          UP_SAT   = 1'b1,
  parameter bit          DN_SAT   = 1'b1,
  parameter int unsigned UP_LIMIT = (1 << WIDTH) - 1,
  parameter int unsigned DN_LIMIT = 0
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             load_i,
  input logic             inc_i,
  input logic             dec_i,
  input logic [WIDTH-1:0] cnt_o,
  input logic             overflow_o,
  input logic             underflow_o
);
  localparam int unsigned MAXV = (1 << WIDTH) - 1;

  // R1
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !inc_i && !dec_i) |=> $stable(cnt_o));

  // R9
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i |-> !overflow_o);

  // R10
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec_i |-> !underflow_o);

  // R9
  wrap_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overflow_o && !dec_i && !load_i) |=> (cnt_o < $past(cnt_o)));

  if (UP_SAT && (UP_LIMIT < MAXV)) begin : g_up
    // R6
    ceiling_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_o <= WIDTH'(UP_LIMIT));
  end

  if (DN_SAT && (DN_LIMIT > 0)) begin : g_dn
    // R7
    floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_o >= WIDTH'(DN_LIMIT));
  end
endmodule

bind ctr_field ctr_field_chk #(
  .WIDTH(WIDTH), .UP_SAT(UP_SAT), .DN_SAT(DN_SAT),
  .UP_LIMIT(UP_LIMIT), .DN_LIMIT(DN_LIMIT)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .inc_i(inc_i), .dec_i(dec_i),
  .cnt_o(cnt_o), .overflow_o(overflow_o), .underflow_o(underflow_o)
);

// File: tb/ctr_field_test.sv
module ctr_field_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // saturating instance: ceiling 200, floor 10, thresholds 150/20, reset 50
  logic       ld, inc, dec;
  logic [7:0] lv, cnt;
  logic [3:0] istep, dstep;
  logic       uthr, dthr, usat, dsat, ovf, unf;

  ctr_field #(
    .WIDTH(8), .STEP_W(4), .UP_SAT(1'b1), .DN_SAT(1'b1),
    .UP_LIMIT(200), .DN_LIMIT(10), .UP_THRESH(150), .DN_THRESH(20), .RESET_VAL(50)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .load_i(ld), .load_val_i(lv), .inc_i(inc), .dec_i(dec),
    .inc_step_i(istep), .dec_step_i(dstep), .cnt_o(cnt), .up_thr_o(uthr), .dn_thr_o(dthr),
    .up_sat_o(usat), .dn_sat_o(dsat), .overflow_o(ovf), .underflow_o(unf)
  );

  // wrapping instance: 4 bits, fixed step 1, reset 0
  logic       w_ld, w_inc, w_dec;
  logic [3:0] w_lv, w_cnt;
  logic       w_istep, w_dstep;
  logic       w_uthr, w_dthr, w_usat, w_dsat, w_ovf, w_unf;

  ctr_field #(
    .WIDTH(4), .STEP_W(0), .UP_SAT(1'b0), .DN_SAT(1'b0), .RESET_VAL(0)
  ) uut_w (
    .clk_i(clk), .rst_ni(rst_n), .load_i(w_ld), .load_val_i(w_lv), .inc_i(w_inc), .dec_i(w_dec),
    .inc_step_i(w_istep), .dec_step_i(w_dstep), .cnt_o(w_cnt), .up_thr_o(w_uthr),
    .dn_thr_o(w_dthr), .up_sat_o(w_usat), .dn_sat_o(w_dsat), .overflow_o(w_ovf),
    .underflow_o(w_unf)
  );

  typedef struct packed {
    logic       ld;
    logic [7:0] lv;
    logic       inc;
    logic       dec;
    logic [3:0] is;
    logic [3:0] ds;
    logic [7:0] exp;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'd0,   1'b1, 1'b0, 4'd5,  4'd0,  8'd55},  // R2
    '{1'b0, 8'd0,   1'b0, 1'b1, 4'd0,  4'd3,  8'd52},  // R3
    '{1'b0, 8'd0,   1'b1, 1'b1, 4'd7,  4'd2,  8'd57},  // R4
    '{1'b1, 8'd100, 1'b1, 1'b0, 4'd4,  4'd0,  8'd104}, // R5
    '{1'b1, 8'd198, 1'b1, 1'b0, 4'd5,  4'd0,  8'd200}, // R6
    '{1'b0, 8'd0,   1'b0, 1'b0, 4'd9,  4'd9,  8'd200}, // R1
    '{1'b0, 8'd0,   1'b0, 1'b1, 4'd0,  4'd15, 8'd185}, // R3
    '{1'b1, 8'd12,  1'b0, 1'b1, 4'd0,  4'd3,  8'd10},  // R7
    '{1'b1, 8'd250, 1'b0, 1'b0, 4'd0,  4'd0,  8'd200}, // R8
    '{1'b1, 8'd5,   1'b0, 1'b0, 4'd0,  4'd0,  8'd10},  // R8
    '{1'b1, 8'd195, 1'b1, 1'b1, 4'd10, 4'd4,  8'd196}, // R4 at ceiling
    '{1'b1, 8'd14,  1'b1, 1'b1, 4'd1,  4'd8,  8'd10}   // R4 at floor
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_sat_flags(input int v);
    // R11 thresholds 150/20, R12 limits 200/10
    check(uthr == (v >= 150), "R11 up_thr", uthr, int'(v >= 150));
    check(dthr == (v <= 20),  "R11 dn_thr", dthr, int'(v <= 20));
    check(usat == (v >= 200), "R12 up_sat", usat, int'(v >= 200));
    check(dsat == (v <= 10),  "R12 dn_sat", dsat, int'(v <= 10));
  endtask

  task automatic w_step(input logic i, input logic d, input logic exp_ovf, input logic exp_unf,
                        input int exp_cnt, input string tag);
    w_inc = i; w_dec = d;
    #2;
    check(w_ovf == exp_ovf, {tag, " overflow"}, w_ovf, exp_ovf);
    check(w_unf == exp_unf, {tag, " underflow"}, w_unf, exp_unf);
    @(negedge clk);
    check(int'(w_cnt) == exp_cnt, {tag, " count"}, w_cnt, exp_cnt);
    w_inc = 1'b0; w_dec = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    ld = 0; lv = 0; inc = 0; dec = 0; istep = 0; dstep = 0;
    w_ld = 0; w_lv = 0; w_inc = 0; w_dec = 0; w_istep = 0; w_dstep = 0;
    repeat (3) @(negedge clk);
    // R1 reset values
    check(cnt == 8'd50, "R1 reset count", cnt, 50);
    check_sat_flags(50);
    check(w_cnt == 4'd0, "R1 wrap reset count", w_cnt, 0);
    check(w_dthr == 1'b1, "R11 wrap dn_thr at 0", w_dthr, 1);
    check(w_dsat == 1'b1, "R12 wrap dn_sat at 0", w_dsat, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(cnt == 8'd50, "R1 hold after reset", cnt, 50);

    for (int k = 0; k < NV; k++) begin
      ld = VECS[k].ld; lv = VECS[k].lv; inc = VECS[k].inc; dec = VECS[k].dec;
      istep = VECS[k].is; dstep = VECS[k].ds;
      #2;
      // R9 R10 saturating directions never flag a wrap
      check(ovf == 1'b0, "R9 sat overflow", ovf, 0);
      check(unf == 1'b0, "R10 sat underflow", unf, 0);
      @(negedge clk);
      check(cnt == VECS[k].exp, $sformatf("R2-vector %0d count", k), cnt, VECS[k].exp);
      check_sat_flags(int'(VECS[k].exp));
    end
    ld = 0; inc = 0; dec = 0;

    // R10 wrap below zero: 0 - 1 = 15
    w_step(1'b0, 1'b1, 1'b0, 1'b1, 15, "R10 wrap dec at 0");
    check(w_usat == 1'b1, "R12 wrap up_sat at 15", w_usat, 1);
    check(w_uthr == 1'b1, "R11 wrap up_thr at 15", w_uthr, 1);
    // R9 wrap above max: 15 + 1 = 0
    w_step(1'b1, 1'b0, 1'b1, 1'b0, 0, "R9 wrap inc at 15");
    // R2 fixed step of one, no overflow
    w_step(1'b1, 1'b0, 1'b0, 1'b0, 1, "R2 fixed step inc");
    // R9 R10 idle: no flags, value held
    w_step(1'b0, 1'b0, 1'b0, 1'b0, 1, "R9 wrap idle");
    // R3 fixed step dec without wrap
    w_step(1'b0, 1'b1, 1'b0, 1'b0, 0, "R3 fixed step dec");
    // R4 both strobes at 15: inc wraps to 0, dec wraps back to 15
    w_ld = 1'b1; w_lv = 4'd15;
    w_step(1'b1, 1'b1, 1'b1, 1'b1, 15, "R4 wrap both strobes");
    w_ld = 1'b0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule